// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Burst SRAM

This block is a synthesizable, cycle-level model of a small synchronous static memory. It accepts a new read or write on every clock, so no idle cycles are needed when the bus turns from reading to writing. Each access is started by a load, which captures the address, the direction and the byte enables. A four-word burst can then be stepped by advance cycles, in either a linear order or an interleaved order. Read data and write data both trail their address by two enabled clock edges.

A write that is still in flight is forwarded, byte by byte, to a read of the same word that follows it immediately. An active-low clock enable freezes every register in the block for one edge. Three chip-select pins gate whether a load starts an access. A registered output slot, gated by an output enable, presents read data together with a valid flag that stands in for the high-impedance state.

Top module: `zbt_sram`

## Requirements
- R1: A selected load with `rd_nwr`=1 at enabled edge E0 makes `dout` carry the stored word, with `dout_vld`=1, after enabled edge E0+2 while `oe_n` is low.
- R2: A selected load with `rd_nwr`=0 samples `bw_n` on the load edge and `din` on the second enabled edge after it. Bit i of `bw_n`, when low, writes `din[9i+8:9i]`. Bytes whose bit is high keep their old value, and a write never raises `dout_vld`.
- R3: With `adv_nld`=1, the burst continues with the upper address bits held. For advance k=1,2,3, the low two address bits are start+k mod 4 if `lin_order` was 1 at load, and start XOR k if it was 0. The fifth word wraps back to the start address.
- R4: The direction and the burst order are fixed at load. `rd_nwr` and `lin_order` are ignored on advance cycles.
- R5: A load ends any burst in progress. The next access uses the newly loaded address.
- R6: An edge with `cen_n`=1 is ignored. All pipeline stages, burst state and the output slot keep their values, and the output shows the same data.
- R7: The chip is selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. A deselected load produces no access and ends the burst. Advance cycles after it also produce no access.
- R8: `dout_vld`=1 only when `oe_n` is low and the output slot holds read data. Otherwise `dout_vld`=0 and `dout` is all zeros.
- R9: A read loaded on the edge right after a write to the same address returns the old word merged with the enabled bytes of that write's data.
- R10: A low `rst_n` on an edge clears the pipeline valid flags and the burst state. It leaves the memory contents intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cen_n | input | 1 | Clock enable, active low |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| adv_nld | input | 1 | 1 = advance burst, 0 = load new access |
| rd_nwr | input | 1 | 1 = read, 0 = write (sampled at load) |
| bw_n | input | BYTES | Byte write enables, active low |
| addr | input | ADDR_W | Word address |
| din | input | BYTES*BYTE_W | Write data |
| oe_n | input | 1 | Output enable, active low |
| lin_order | input | 1 | 1 = linear burst order, 0 = interleaved |
| dout | output | BYTES*BYTE_W | Read data, zero when not driven |
| dout_vld | output | 1 | High when `dout` is driven with read data |

## Verification
A read result is due after the second enabled edge that follows its load edge. Write data is due at the input on that same second enabled edge. Edges with `cen_n` high do not count toward either delay. The bench drives inputs at the falling edge and samples 5 ns after each rising edge. Each expected value is placed on the row or call that matches its cycle: table rows carry their expected output, and the directed tests compare only after the counted number of cycles. The forwarding, byte-merge and freeze cases are checked through the outputs alone.

// File: rtl/zbt_pkg.sv
// Package: shared helpers for the pipelined burst SRAM.
// Assumes bursts are four words long and stepped on address bits 1:0.
package zbt_pkg;

    // Low two address bits of burst word 'step' from start 'base'
    function automatic logic [1:0] burst_lo(input logic [1:0] base,
                                            input logic [1:0] step,
                                            input logic       linear);
        return linear ? (base + step) : (base ^ step);
    endfunction

endpackage

// File: rtl/zbt_burst_ctrl.sv
// Burst controller: turns each enabled edge into at most one access request.
// A load takes the pins directly. An advance steps a 2-bit counter and reuses
// the direction and order captured at load. Assumes ADDR_W >= 3.
module zbt_burst_ctrl #(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              load,
    input  logic              sel,
    input  logic              rd_nwr,
    input  logic              lin_order,
    input  logic [BYTES-1:0]  bw_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              req_vld,
    output logic              req_wr,
    output logic [ADDR_W-1:0] req_addr,
    output logic [BYTES-1:0]  req_be
);
    import zbt_pkg::*;

    logic              act_q;
    logic              wr_q;
    logic              lin_q;
    logic [ADDR_W-1:0] base_q;
    logic [1:0]        cnt_q;
    logic [1:0]        step;

    assign step = cnt_q + 2'd1;

    // Select the request for this edge: fresh load or next burst word
    always_comb begin
        req_be = ~bw_n;
        if (load) begin
            req_vld  = sel;
            req_wr   = ~rd_nwr;
            req_addr = addr;
        end else begin
            req_vld  = act_q;
            req_wr   = wr_q;
            req_addr = {base_q[ADDR_W-1:2], burst_lo(base_q[1:0], step, lin_q)};
        end
    end

    // Hold burst state; capture it at load and step it on advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            cnt_q <= 2'd0;
        end else if (ce) begin
            if (load) begin
                act_q  <= sel;
                wr_q   <= ~rd_nwr;
                lin_q  <= lin_order;
                base_q <= addr;
                cnt_q  <= 2'd0;
            end else if (act_q) begin
                cnt_q <= step;
            end
        end
    end

endmodule

// File: rtl/zbt_store.sv
// Storage array split into independent byte lanes, with a write-to-read bypass.
// The read port is combinational. When the word being written on this edge
// matches the read address, the enabled bytes come from the write data.
// Contents are never reset.
module zbt_store #(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 4,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic                    ce,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [BYTES-1:0]        wr_be,
    input  logic [BYTES*BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [BYTES*BYTE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic hit;
    assign hit = wr_en && (wr_addr == rd_addr);

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        logic [BYTE_W-1:0] lane [DEPTH];

        // Commit this lane when its byte enable is set
        always_ff @(posedge clk) begin
            if (ce && wr_en && wr_be[b]) begin
                lane[wr_addr] <= wr_data[b*BYTE_W +: BYTE_W];
            end
        end

        // Read this lane, bypassing the in-flight write byte
        always_comb begin
            rd_data[b*BYTE_W +: BYTE_W] = (hit && wr_be[b]) ?
                wr_data[b*BYTE_W +: BYTE_W] : lane[rd_addr];
        end
    end

endmodule

// File: rtl/zbt_sram.sv
// Top of the pipelined burst SRAM.
// Stage 1 holds the request taken at the load/advance edge. Stage 2 reads the
// array, with forwarding. The output slot takes read data on the next edge, so
// results appear two enabled edges after the address. Writes commit with din
// when the request leaves stage 2. cen_n high freezes every register.
module zbt_sram #(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 4,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cen_n,
    input  logic                    cs1_n,
    input  logic                    cs2,
    input  logic                    cs3_n,
    input  logic                    adv_nld,
    input  logic                    rd_nwr,
    input  logic [BYTES-1:0]        bw_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [BYTES*BYTE_W-1:0] din,
    input  logic                    oe_n,
    input  logic                    lin_order,
    output logic [BYTES*BYTE_W-1:0] dout,
    output logic                    dout_vld
);
    localparam int DATA_W = BYTES * BYTE_W;

    logic              ce;
    logic              sel;
    logic              req_vld;
    logic              req_wr;
    logic [ADDR_W-1:0] req_addr;
    logic [BYTES-1:0]  req_be;

    logic              s1_vld, s1_wr;
    logic [ADDR_W-1:0] s1_addr;
    logic [BYTES-1:0]  s1_be;
    logic              s2_vld, s2_wr;
    logic [ADDR_W-1:0] s2_addr;
    logic [BYTES-1:0]  s2_be;
    logic [DATA_W-1:0] s2_rdata;
    logic [DATA_W-1:0] rd_word;
    logic              dq_vld;
    logic [DATA_W-1:0] dq_data;

    assign ce  = ~cen_n;
    assign sel = ~cs1_n & cs2 & ~cs3_n;

    zbt_burst_ctrl #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce        (ce),
        .load      (~adv_nld),
        .sel       (sel),
        .rd_nwr    (rd_nwr),
        .lin_order (lin_order),
        .bw_n      (bw_n),
        .addr      (addr),
        .req_vld   (req_vld),
        .req_wr    (req_wr),
        .req_addr  (req_addr),
        .req_be    (req_be)
    );

    zbt_store #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_store (
        .clk     (clk),
        .ce      (ce),
        .wr_en   (s2_vld & s2_wr),
        .wr_addr (s2_addr),
        .wr_be   (s2_be),
        .wr_data (din),
        .rd_addr (s1_addr),
        .rd_data (rd_word)
    );

    // Valid flags of both stages and the output slot; cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
            s2_vld <= 1'b0;
            dq_vld <= 1'b0;
        end else if (ce) begin
            s1_vld <= req_vld;
            s2_vld <= s1_vld;
            dq_vld <= s2_vld & ~s2_wr;
        end
    end

    // Payload of the stages and the output slot; frozen when cen_n is high
    always_ff @(posedge clk) begin
        if (ce) begin
            s1_wr    <= req_wr;
            s1_addr  <= req_addr;
            s1_be    <= req_be;
            s2_wr    <= s1_wr;
            s2_addr  <= s1_addr;
            s2_be    <= s1_be;
            s2_rdata <= rd_word;
            if (s2_vld && !s2_wr) begin
                dq_data <= s2_rdata;
            end
        end
    end

    // Drive the output only with valid read data and oe_n low
    always_comb begin
        dout_vld = ~oe_n & dq_vld;
        dout     = dout_vld ? dq_data : '0;
    end

endmodule

// File: rtl/zbt_sram_chk.sv
// Checker for zbt_sram: temporal rules over the stage flags and the output
// slot. Attached to every instance of the top by the bind at the end.
module zbt_sram_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cen_n,
    input logic              adv_nld,
    input logic              rd_nwr,
    input logic              sel,
    input logic              s1_vld,
    input logic              s1_wr,
    input logic              s2_vld,
    input logic              s2_wr,
    input logic              dq_vld,
    input logic [DATA_W-1:0] dq_data
);

    AST_READ_TO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && s2_vld && !s2_wr) |=> dq_vld); // R1

    AST_WRITE_NO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && s2_vld && s2_wr) |=> !dq_vld); // R2

    AST_LOAD_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !adv_nld && sel) |=> (s1_vld && (s1_wr == !$past(rd_nwr)))); // R4

    AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        cen_n |=> ($stable(dq_data) && $stable(dq_vld) && $stable(s1_vld) && $stable(s2_vld))); // R6

    AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !adv_nld && !sel) |=> !s1_vld); // R7

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!s1_vld && !s2_vld && !dq_vld)); // R10

endmodule

bind zbt_sram zbt_sram_chk #(.DATA_W(BYTES*BYTE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cen_n   (cen_n),
    .adv_nld (adv_nld),
    .rd_nwr  (rd_nwr),
    .sel     (sel),
    .s1_vld  (s1_vld),
    .s1_wr   (s1_wr),
    .s2_vld  (s2_vld),
    .s2_wr   (s2_wr),
    .dq_vld  (dq_vld),
    .dq_data (dq_data)
);

// File: tb/zbt_sram_bench.sv
// Bench for zbt_sram: one table walk, then directed corner tests.
module zbt_sram_bench;

    localparam int ADDR_W = 6;
    localparam int BYTES  = 4;
    localparam int BYTE_W = 9;
    localparam int DW     = BYTES * BYTE_W;

    localparam logic [DW-1:0] D10 = 36'h123456789;
    localparam logic [DW-1:0] D11 = 36'h9abcdef01;
    localparam logic [DW-1:0] W0  = 36'h0a0a0a0a0;
    localparam logic [DW-1:0] W1  = 36'h1b1b1b1b1;
    localparam logic [DW-1:0] W2  = 36'h2c2c2c2c2;
    localparam logic [DW-1:0] W3  = 36'h3d3d3d3d3;
    localparam logic [DW-1:0] PF  = 36'h111111111;
    localparam logic [DW-1:0] QF  = 36'heeeeeeeee;

    typedef struct packed {
        logic              cen_n;
        logic              adv;
        logic              rd;
        logic              sel;
        logic [BYTES-1:0]  bw_n;
        logic [ADDR_W-1:0] addr;
        logic [DW-1:0]     din;
        logic              lin;
        logic              chk;
        logic              evld;
        logic [DW-1:0]     exp;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 1'b0, 1'b0, 1'b1, 4'h0, 6'h10, 36'h0, 1'b1, 1'b0, 1'b0, 36'h0},
        '{1'b0, 1'b0, 1'b0, 1'b1, 4'h0, 6'h11, 36'h0, 1'b1, 1'b0, 1'b0, 36'h0},
        '{1'b0, 1'b0, 1'b1, 1'b1, 4'h0, 6'h10, D10,   1'b1, 1'b1, 1'b0, 36'h0},
        '{1'b0, 1'b0, 1'b1, 1'b1, 4'h0, 6'h11, D11,   1'b1, 1'b0, 1'b0, 36'h0},
        '{1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 6'h00, 36'h0, 1'b1, 1'b1, 1'b1, D10},
        '{1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 6'h00, 36'h0, 1'b1, 1'b1, 1'b1, D11},
        '{1'b0, 1'b0, 1'b0, 1'b1, 4'h0, 6'h22, 36'h0, 1'b1, 1'b1, 1'b0, 36'h0},
        '{1'b0, 1'b1, 1'b1, 1'b1, 4'h0, 6'h00, 36'h0, 1'b0, 1'b0, 1'b0, 36'h0},
        '{1'b0, 1'b1, 1'b0, 1'b1, 4'h0, 6'h00, W0,    1'b1, 1'b0, 1'b0, 36'h0},
        '{1'b0, 1'b1, 1'b1, 1'b1, 4'h0, 6'h00, W1,    1'b1, 1'b0, 1'b0, 36'h0},
        '{1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 6'h00, W2,    1'b1, 1'b0, 1'b0, 36'h0},
        '{1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 6'h00, W3,    1'b1, 1'b0, 1'b0, 36'h0},
        '{1'b0, 1'b0, 1'b1, 1'b1, 4'h0, 6'h21, 36'h0, 1'b0, 1'b0, 1'b0, 36'h0},
        '{1'b0, 1'b1, 1'b0, 1'b1, 4'h0, 6'h00, 36'h0, 1'b1, 1'b0, 1'b0, 36'h0},
        '{1'b0, 1'b1, 1'b0, 1'b1, 4'h0, 6'h00, 36'h0, 1'b1, 1'b1, 1'b1, W3},
        '{1'b0, 1'b1, 1'b1, 1'b1, 4'h0, 6'h00, 36'h0, 1'b1, 1'b1, 1'b1, W2},
        '{1'b0, 1'b1, 1'b1, 1'b1, 4'h0, 6'h00, 36'h0, 1'b1, 1'b1, 1'b1, W1},
        '{1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 6'h00, 36'h0, 1'b1, 1'b1, 1'b1, W0},
        '{1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 6'h00, 36'h0, 1'b1, 1'b1, 1'b1, W3},
        '{1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 6'h00, 36'h0, 1'b1, 1'b1, 1'b0, 36'h0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cen_n = 1'b0;
    logic              cs1_n = 1'b1;
    logic              cs2 = 1'b0;
    logic              cs3_n = 1'b1;
    logic              adv_nld = 1'b0;
    logic              rd_nwr = 1'b1;
    logic [BYTES-1:0]  bw_n = '1;
    logic [ADDR_W-1:0] addr = '0;
    logic [DW-1:0]     din = '0;
    logic              oe_n = 1'b0;
    logic              lin_order = 1'b1;
    logic [DW-1:0]     dout;
    logic              dout_vld;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    zbt_sram #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_zbt_sram (
        .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .cs1_n(cs1_n), .cs2(cs2),
        .cs3_n(cs3_n), .adv_nld(adv_nld), .rd_nwr(rd_nwr), .bw_n(bw_n),
        .addr(addr), .din(din), .oe_n(oe_n), .lin_order(lin_order),
        .dout(dout), .dout_vld(dout_vld)
    );

    // One cycle: drive at the falling edge, return 5 ns after the rising edge
    task automatic cyc(input logic c_n, input logic adv, input logic rd,
                       input logic s, input logic [BYTES-1:0] bw,
                       input logic [ADDR_W-1:0] a, input logic [DW-1:0] d,
                       input logic lin);
        @(negedge clk);
        cen_n = c_n; adv_nld = adv; rd_nwr = rd; bw_n = bw;
        cs1_n = ~s; cs2 = s; cs3_n = ~s;
        addr = a; din = d; lin_order = lin;
        @(posedge clk);
        #5;
    endtask

    task automatic nop();
        cyc(1'b0, 1'b0, 1'b1, 1'b0, '1, '0, '0, 1'b1);
    endtask

    task automatic check(input string req, input logic ev, input logic [DW-1:0] ed);
        logic [DW-1:0] want;
        want = ev ? ed : '0;
        checks++;
        if (dout_vld !== ev || dout !== want) begin
            errors++;
            $display("FAIL %s: got vld=%0b data=%h, expected vld=%0b data=%h",
                     req, dout_vld, dout, ev, want);
        end
    endtask

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                            input logic [DW-1:0] new_w,
                                            input logic [BYTES-1:0] bwn);
        logic [DW-1:0] r;
        r = old_w;
        for (int i = 0; i < BYTES; i++) begin
            if (!bwn[i]) r[i*BYTE_W +: BYTE_W] = new_w[i*BYTE_W +: BYTE_W];
        end
        return r;
    endfunction

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R10: reset state of the output
        cyc(1'b0, 1'b0, 1'b1, 1'b0, '1, '0, '0, 1'b1);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, '1, '0, '0, 1'b1);
        check("R10 reset state", 1'b0, '0);
        rst_n = 1'b1;
        nop();

        // R1 R2 R3 R4 R7: table of per-cycle stimulus and expected output
        for (int i = 0; i < NV; i++) begin
            cyc(TBL[i].cen_n, TBL[i].adv, TBL[i].rd, TBL[i].sel, TBL[i].bw_n,
                TBL[i].addr, TBL[i].din, TBL[i].lin);
            if (TBL[i].chk) check($sformatf("R1 R2 R3 R4 table row %0d", i),
                                  TBL[i].evld, TBL[i].exp);
        end

        // R2: byte-masked write over a full word
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 4'h0, 6'h30, '0, 1'b1);
        nop();
        cyc(1'b0, 1'b0, 1'b1, 1'b0, '1, '0, PF, 1'b1);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 4'b1010, 6'h30, '0, 1'b1);
        nop();
        cyc(1'b0, 1'b0, 1'b1, 1'b0, '1, '0, QF, 1'b1);
        cyc(1'b0, 1'b0, 1'b1, 1'b1, '1, 6'h30, '0, 1'b1);
        nop();
        nop();
        check("R2 byte mask", 1'b1, merge(PF, QF, 4'b1010));

        // R9: read loaded right after a partial write to the same word
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 4'b1100, 6'h30, '0, 1'b1);
        cyc(1'b0, 1'b0, 1'b1, 1'b1, '1, 6'h30, '0, 1'b1);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, '1, '0, W1, 1'b1);
        check("R9 before result", 1'b0, '0);
        nop();
        check("R9 forward", 1'b1, merge(merge(PF, QF, 4'b1010), W1, 4'b1100));

        // R6: frozen edges do not count and hold the output slot
        cyc(1'b0, 1'b0, 1'b1, 1'b1, '1, 6'h10, '0, 1'b1);
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 4'h0, 6'h11, '0, 1'b1);
        nop();
        cyc(1'b1, 1'b0, 1'b1, 1'b1, '1, 6'h11, '0, 1'b1);
        check("R6 frozen delay", 1'b0, '0);
        nop();
        check("R6 result after freeze", 1'b1, D10);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, '1, '0, '0, 1'b1);
        check("R6 output held", 1'b1, D10);
        nop();
        check("R6 slot empties", 1'b0, '0);

        // R8: output enable gates valid read data
        cyc(1'b0, 1'b0, 1'b1, 1'b1, '1, 6'h11, '0, 1'b1);
        nop();
        @(negedge clk);
        cen_n = 1'b0; adv_nld = 1'b0; cs1_n = 1'b1; cs2 = 1'b0; cs3_n = 1'b1;
        oe_n = 1'b1;
        @(posedge clk);
        #5;
        check("R8 oe_n high", 1'b0, '0);
        oe_n = 1'b0;
        #1;
        check("R8 oe_n low", 1'b1, D11);

        // R5: a load cuts a burst short
        cyc(1'b0, 1'b0, 1'b1, 1'b1, '1, 6'h20, '0, 1'b1);
        cyc(1'b0, 1'b1, 1'b1, 1'b1, '1, '0, '0, 1'b1);
        cyc(1'b0, 1'b0, 1'b1, 1'b1, '1, 6'h11, '0, 1'b1);
        check("R5 first word", 1'b1, W2);
        nop();
        check("R5 second word", 1'b1, W3);
        nop();
        check("R5 new load", 1'b1, D11);
        nop();
        check("R5 burst ended", 1'b0, '0);

        // R7: each chip select alone blocks the access; advances after do nothing
        @(negedge clk);
        cen_n = 1'b0; adv_nld = 1'b0; rd_nwr = 1'b1; addr = 6'h10;
        cs1_n = 1'b0; cs2 = 1'b0; cs3_n = 1'b0;
        @(negedge clk);
        cs1_n = 1'b1; cs2 = 1'b1; cs3_n = 1'b0;
        @(negedge clk);
        cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b1;
        @(negedge clk);
        adv_nld = 1'b1; cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b0;
        @(posedge clk);
        #5;
        check("R7 partial selects", 1'b0, '0);
        cyc(1'b0, 1'b1, 1'b1, 1'b1, '1, '0, '0, 1'b1);
        check("R7 advance idle", 1'b0, '0);
        cyc(1'b0, 1'b1, 1'b1, 1'b1, '1, '0, '0, 1'b1);
        check("R7 advance idle 2", 1'b0, '0);

        // R10: reset mid-burst drops state, keeps memory
        cyc(1'b0, 1'b0, 1'b1, 1'b1, '1, 6'h20, '0, 1'b1);
        cyc(1'b0, 1'b1, 1'b1, 1'b1, '1, '0, '0, 1'b1);
        rst_n = 1'b0;
        cyc(1'b0, 1'b1, 1'b1, 1'b1, '1, '0, '0, 1'b1);
        check("R10 reset clears slot", 1'b0, '0);
        rst_n = 1'b1;
        cyc(1'b0, 1'b1, 1'b1, 1'b1, '1, '0, '0, 1'b1);
        check("R10 no pending output", 1'b0, '0);
        nop();
        check("R10 burst cleared", 1'b0, '0);
        cyc(1'b0, 1'b0, 1'b1, 1'b1, '1, 6'h10, '0, 1'b1);
        nop();
        nop();
        check("R10 memory kept", 1'b1, D10);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule